// File: doc/BRIEF.md
# Byte-Wide SPI Master with Completion and Collision Flags

The block is a CPU-controlled serial peripheral that moves one byte at a time over a four-wire serial link in mode 0. In mode 0 the clock idles low, the block samples on the rising edge and shifts on the falling edge. The most significant bit goes first. Software reaches three registers through a select/read/write bus. A control register picks master operation, interrupt enable, slave-select sensing and two rate bits. A status register carries the completion flag, the collision flag and a speed-doubling bit. A data register starts a transfer when written and returns the last received byte when read.

The serial clock runs at the system clock divided by 2 to 128. The divider is chosen by a three-bit code built from the doubling bit and the two rate bits. Completion and collision are sticky flags. Software clears them by reading status while the flag is set and then touching the data register, or clears the completion flag with an interrupt acknowledge. If slave-select sensing is on, a low level on the slave-select input while in master mode also sets the completion flag.

Register select: 0 = control, 1 = status, 2 = data, 3 = reads as zero.

Top module: `spi_byte_master`

## Requirements
- R1: In master mode the serial clock period, in system clocks, follows the code {status bit 0, control bit 1, control bit 0}: 000=4, 001=16, 010=64, 011=128, 100=2, 101=8, 110=32, 111=64.
- R2: With control bit 4 (master) at 0, the serial clock stays low whatever the rate code is. A data write then starts nothing and sets no flag.
- R3: A data write in master mode while idle sends the byte MSB first on mosi and samples miso on each rising serial clock edge. After 8 bits, status bit 7 (completion) is set and a data read returns the received byte.
- R4: irq is high exactly while status bit 7 is set, control bit 7 (interrupt enable) is 1 and the gie input is 1.
- R5: A one-cycle pulse on irq_ack clears status bit 7.
- R6: A data write during a transfer sets status bit 6 (collision). The written byte is discarded and the byte in flight completes unchanged.
- R7: Status bits 5 to 1 always read 0. Status bit 0 is writable and readable.
- R8: A status read that sees a flag set, followed by a data read or write, clears that flag. A data access with no such prior status read leaves the flags set.
- R9: A flag-setting event in the same cycle as the clearing data access leaves the flag set.
- R10: With control bit 2 (slave-select sensing) and master set, ss_n_in low sets status bit 7.
- R11: After reset all registers read 0, and sck, mosi and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| ss_n_in | input | 1 | Slave-select input, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The flag-clearing data access and a flag-setting event can land in the same cycle. The bench forces this by holding slave-select low with sensing enabled, reading status and then reading data. The flag must still read as set afterwards, and it must clear once slave-select is released and the sequence is repeated. A second coincidence is a data write that both finishes a clear sequence for the collision flag and collides again. Here the collision flag has to stay set while the byte in flight arrives intact at the bench's slave model.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int CTRL_IE   = 7;
    localparam int CTRL_MSTR = 4;
    localparam int CTRL_SSIN = 2;

    // half of the serial clock period in system clocks
    function automatic int unsigned half_of(input logic [2:0] code);
        case (code)
            3'b000:  return 2;
            3'b001:  return 8;
            3'b010:  return 32;
            3'b011:  return 64;
            3'b100:  return 1;
            3'b101:  return 4;
            3'b110:  return 16;
            default: return 32;
        endcase
    endfunction
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rg_t;

    rg_t rg_d, rg_q;
    logic [CNT_W-1:0] half;

    always_comb begin
        half = CNT_W'(half_of(code));
        rg_d = rg_q;
        tick = run && (rg_q.cnt == half - 1'b1);
        if (!run || tick) begin
            rg_d.cnt = '0;
        end else begin
            rg_d.cnt = rg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx
);
    localparam int EW = $clog2(2 * DW);
    localparam logic [EW-1:0] LAST = EW'(2 * DW - 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic          cap;
        logic [EW-1:0] edges;
        logic [DW-1:0] sr;
    } se_t;

    se_t se_d, se_q;

    always_comb begin
        se_d = se_q;
        done = 1'b0;
        if (!se_q.busy) begin
            if (start) begin
                se_d.busy  = 1'b1;
                se_d.sr    = tx;
                se_d.edges = '0;
                se_d.sck   = 1'b0;
            end
        end else if (tick) begin
            if (!se_q.sck) begin
                se_d.sck = 1'b1;
                se_d.cap = miso;
            end else begin
                se_d.sck = 1'b0;
                se_d.sr  = {se_q.sr[DW-2:0], se_q.cap};
                if (se_q.edges == LAST) begin
                    se_d.busy = 1'b0;
                    done      = 1'b1;
                end
            end
            se_d.edges = se_q.edges + 1'b1;
        end
    end

    assign busy = se_q.busy;
    assign sck  = se_q.sck;
    assign mosi = se_q.sr[DW-1];
    assign rx   = {se_q.sr[DW-2:0], se_q.cap};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) se_q <= '0;
        else        se_q <= se_d;
    end
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          irq_ack,
    input  logic          gie,
    input  logic          ss_n_in,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] rx,
    output logic          start,
    output logic [2:0]    code,
    output logic          master,
    output logic          irq,
    output logic          spif,
    output logic          wcol
);
    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          dbl;
        logic          spif;
        logic          wcol;
        logic          arm_f;
        logic          arm_w;
        logic [DW-1:0] rxbuf;
    } rf_t;

    rf_t rf_d, rf_q;
    logic stat_rd, data_acc, collide, ss_evt, set_f;
    logic [DW-1:0] stat;

    always_comb begin
        stat         = '0;
        stat[DW-1]   = rf_q.spif;
        stat[DW-2]   = rf_q.wcol;
        stat[0]      = rf_q.dbl;

        stat_rd  = bus_rd && (bus_sel == SEL_STAT);
        data_acc = (bus_rd || bus_wr) && (bus_sel == SEL_DATA);
        start    = bus_wr && (bus_sel == SEL_DATA) && rf_q.ctrl[CTRL_MSTR] && !busy;
        collide  = bus_wr && (bus_sel == SEL_DATA) && busy;
        ss_evt   = rf_q.ctrl[CTRL_MSTR] && rf_q.ctrl[CTRL_SSIN] && !ss_n_in;
        set_f    = done || ss_evt;

        rf_d = rf_q;
        if (bus_wr && bus_sel == SEL_CTRL) rf_d.ctrl = bus_wdata;
        if (bus_wr && bus_sel == SEL_STAT) rf_d.dbl  = bus_wdata[0];
        if (done) rf_d.rxbuf = rx;

        // completion flag: set wins over every clear
        if (set_f)                         rf_d.spif = 1'b1;
        else if (irq_ack)                  rf_d.spif = 1'b0;
        else if (data_acc && rf_q.arm_f)   rf_d.spif = 1'b0;

        if (stat_rd && rf_q.spif)          rf_d.arm_f = 1'b1;
        else if (data_acc || irq_ack)      rf_d.arm_f = 1'b0;

        // collision flag
        if (collide)                       rf_d.wcol = 1'b1;
        else if (data_acc && rf_q.arm_w)   rf_d.wcol = 1'b0;

        if (stat_rd && rf_q.wcol)          rf_d.arm_w = 1'b1;
        else if (data_acc)                 rf_d.arm_w = 1'b0;

        case (bus_sel)
            SEL_CTRL: bus_rdata = rf_q.ctrl;
            SEL_STAT: bus_rdata = stat;
            SEL_DATA: bus_rdata = rf_q.rxbuf;
            default:  bus_rdata = '0;
        endcase
    end

    assign code   = {rf_q.dbl, rf_q.ctrl[1:0]};
    assign master = rf_q.ctrl[CTRL_MSTR];
    assign irq    = rf_q.spif && rf_q.ctrl[CTRL_IE] && gie;
    assign spif   = rf_q.spif;
    assign wcol   = rf_q.wcol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
    parameter int DW    = 8,
    parameter int CNT_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          irq_ack,
    input  logic          gie,
    output logic          irq,
    input  logic          ss_n_in,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    logic          busy, done, tick, start, master, spif, wcol;
    logic [2:0]    code;
    logic [DW-1:0] rx;

    spi_reg_file #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .gie(gie), .ss_n_in(ss_n_in), .busy(busy),
        .done(done), .rx(rx), .start(start), .code(code), .master(master),
        .irq(irq), .spif(spif), .wcol(wcol)
    );

    spi_rate_gen #(.CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(busy), .code(code), .tick(tick)
    );

    spi_shift_eng #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx(bus_wdata), .tick(tick),
        .miso(miso), .busy(busy), .sck(sck), .mosi(mosi), .done(done), .rx(rx)
    );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       irq_ack,
    input logic       gie,
    input logic       irq,
    input logic       ss_n_in,
    input logic       sck,
    input logic       busy,
    input logic       done,
    input logic       master,
    input logic       spif,
    input logic       wcol
);
    // R2: no serial clock while not a master
    p_sck_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> !sck || $past(sck));

    // R3: end of byte raises completion flag
    p_done_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif);

    // R4: no request without global enable
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    // R5: acknowledge clears flag when nothing sets it
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done && ss_n_in) |=> !spif);

    // R6: write while busy flags a collision
    p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2 && busy) |=> wcol);

    // R7: reserved status bits read zero
    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd1) |-> (bus_rdata[5:1] == 5'd0));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .gie(gie), .irq(irq),
    .ss_n_in(ss_n_in), .sck(sck), .busy(busy), .done(done),
    .master(master), .spif(spif), .wcol(wcol)
);

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0, gie = 1'b0, irq, ss_n_in = 1'b1;
    logic       sck, mosi, miso;

    int checks = 0, fails = 0;
    logic [7:0] slv = 8'd0, cap = 8'd0, rd_v, last_stat;
    int   rise_n = 0;
    realtime last_rise = 0, per = 0;

    always #2 clk = ~clk;

    spi_byte_master i_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .gie(gie), .irq(irq), .ss_n_in(ss_n_in),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    // slave model: mode 0, MSB first
    assign miso = slv[7];
    always @(negedge sck) slv <= {slv[6:0], 1'b0};
    always @(posedge sck) begin
        cap <= {cap[6:0], mosi};
        if (rise_n == 1) per = $realtime - last_rise;
        last_rise = $realtime;
        rise_n = rise_n + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk); bus_sel = s; bus_rd = 1'b1; #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        logic [7:0] v;
        int n;
        n = 0;
        v = 8'd0;
        while (!v[7] && n < 3000) begin rd(2'd1, v); n++; end
        last_stat = v;
        chk(tag, {31'd0, v[7]}, 32'd1);
    endtask

    function automatic int exp_div(input logic [2:0] c);
        int r;
        r = int'(c[1:0]);
        if (r == 3) return c[2] ? 64 : 128;
        return (c[2] ? 2 : 4) << (2 * r);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] pats [3];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hF0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        rd(2'd0, rd_v); chk("R11 ctrl", rd_v, 8'h00);
        rd(2'd1, rd_v); chk("R11 status", rd_v, 8'h00);
        rd(2'd2, rd_v); chk("R11 data", rd_v, 8'h00);
        chk("R11 pins", {sck, mosi, irq}, 3'b000);

        // R7 status layout
        wr(2'd1, 8'hFF); rd(2'd1, rd_v); chk("R7 status bits", rd_v, 8'h01);
        wr(2'd1, 8'h00); rd(2'd1, rd_v); chk("R7 status clear", rd_v, 8'h00);

        // R1 / R3 / R8 sweep over every rate code and several bytes
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 3; p++) begin
                logic [7:0] tx, rxe;
                tx  = pats[p] ^ 8'(c * 17);
                rxe = ~tx ^ 8'(p);
                wr(2'd0, 8'h10 | 8'(c & 3));
                wr(2'd1, 8'(c >> 2));
                slv = rxe;
                rise_n = 0;
                wr(2'd2, tx);
                wait_done("R3 completion flag");
                chk("R1 sck period", int'(per / 4.0), exp_div(3'(c)));
                chk("R3 mosi byte", cap, tx);
                rd(2'd2, rd_v); chk("R3 rx byte", rd_v, rxe);
                rd(2'd1, rd_v); chk("R8 flag cleared", {31'd0, rd_v[7]}, 32'd0);
            end
        end
        wr(2'd1, 8'h00);

        // R8 negative: data access without prior status read
        wr(2'd0, 8'h10); slv = 8'h81; wr(2'd2, 8'h42);
        repeat (80) @(posedge clk);
        rd(2'd2, rd_v); chk("R3 rx late", rd_v, 8'h81);
        rd(2'd1, rd_v); chk("R8 no clear without read", {31'd0, rd_v[7]}, 32'd1);
        rd(2'd2, rd_v); rd(2'd1, rd_v); chk("R8 clear after read", {31'd0, rd_v[7]}, 32'd0);

        // R6 collision during a slow transfer
        wr(2'd0, 8'h13); slv = 8'h5A; rise_n = 0;
        wr(2'd2, 8'hC3);
        repeat (20) @(posedge clk);
        wr(2'd2, 8'h55);
        rd(2'd1, rd_v); chk("R6 collision flag", {31'd0, rd_v[6]}, 32'd1);
        // R9 clear access that collides again
        wr(2'd2, 8'h99);
        rd(2'd1, rd_v); chk("R9 collision stays", {31'd0, rd_v[6]}, 32'd1);
        wait_done("R6 transfer completes");
        chk("R6 mosi unchanged", cap, 8'hC3);
        rd(2'd2, rd_v); chk("R6 rx intact", rd_v, 8'h5A);
        rd(2'd1, rd_v); chk("R6 flags cleared", {24'd0, rd_v[7:6]}, 32'd0);

        // R2 slave mode: rate bits and data writes do nothing
        wr(2'd0, 8'h03); wr(2'd1, 8'h01); rise_n = 0;
        wr(2'd2, 8'hAA);
        repeat (300) @(posedge clk);
        chk("R2 no sck", rise_n, 0);
        rd(2'd1, rd_v); chk("R2 no flag", rd_v, 8'h01);
        wr(2'd1, 8'h00);

        // R10 slave-select low in master mode
        wr(2'd0, 8'h14);
        @(negedge clk); ss_n_in = 1'b0; @(negedge clk); ss_n_in = 1'b1;
        rd(2'd1, rd_v); chk("R10 ss sets flag", {31'd0, rd_v[7]}, 32'd1);
        rd(2'd2, rd_v); rd(2'd1, rd_v); chk("R10 cleared", {31'd0, rd_v[7]}, 32'd0);

        // R9 set event coincides with clearing data access
        @(negedge clk); ss_n_in = 1'b0;
        rd(2'd1, rd_v); rd(2'd2, rd_v);
        rd(2'd1, rd_v); chk("R9 set wins", {31'd0, rd_v[7]}, 32'd1);
        @(negedge clk); ss_n_in = 1'b1;
        rd(2'd1, rd_v); rd(2'd2, rd_v);
        rd(2'd1, rd_v); chk("R9 clear after release", {31'd0, rd_v[7]}, 32'd0);

        // R4 / R5 interrupt gating and acknowledge
        wr(2'd0, 8'h94);
        @(negedge clk); ss_n_in = 1'b0; @(negedge clk); ss_n_in = 1'b1;
        gie = 1'b0; #1 chk("R4 gated by gie", {31'd0, irq}, 32'd0);
        @(negedge clk); gie = 1'b1; #1 chk("R4 irq asserted", {31'd0, irq}, 32'd1);
        wr(2'd0, 8'h14); #1 chk("R4 gated by enable", {31'd0, irq}, 32'd0);
        wr(2'd0, 8'h94);
        @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        #1 chk("R5 irq dropped", {31'd0, irq}, 32'd0);
        rd(2'd1, rd_v); chk("R5 flag cleared", {31'd0, rd_v[7]}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule